// File: doc/BRIEF.md
# Two-wire host register front end

This block is the register-mapped side of a two-wire serial host. Software programs a command code, a target runtime address, a slave register address and write data, then sets the start bit in the control register. The block checks the request, hands it to a separate bit-level serial engine through a start/done/error handshake, and records the outcome in a status register. When the block's interrupt mask and global enable allow it, a level interrupt is raised. Read results are copied into the data register. Their width is set by the command.

The block also sequences two set-up steps that run once. The first is the device-mode initialisation: a word taken from the device-mode register is presented to the engine. The second is the command that assigns a runtime address, which carries a slave's 12-bit hardware address together with the runtime address to give it. A line-control register lets software force either wire to a fixed level, and it reads back the live level of both wires.

Top module: `twb_host_regs`

## Requirements
- R1: After reset every register reads zero, and irq_o, eng_start_o, eng_abort_o and eng_init_o are low. Offsets: control 0x00, clock 0x04, interrupt mask 0x08, status 0x0C, register address 0x10, data 0x1C, line control 0x24, device mode 0x28, command 0x2C, device/runtime address 0x30.
- R2: Control bit 7 is the start bit. Writing it while idle with a legal request pulses eng_start_o for exactly one cycle, in the cycle after the write. Control bit 7 then reads 1 until the transfer ends. Control bit 1 is the global interrupt enable.
- R3: Writing the start bit while a transfer or an initialisation is running sets status bit 2. It does not pulse eng_start_o, and it leaves the running transfer busy.
- R4: A done without error ends the transfer and sets status bit 0. Read commands copy eng_rdata_i into the data register, zero-extended: 0x8B copies 8 bits, 0x9C copies 16 bits and 0xA6 copies 32 bits. Write commands (0x4E, 0x59, 0x63) and 0xE8 leave the data register unchanged.
- R5: A done with error ends the transfer and sets status bit 1. The error byte index goes to status bits 11:8 and the error acknowledge to status bit 16.
- R6: A start is rejected in two cases: the command is none of the seven codes, or the command is 0xE8 and the runtime address is not one of 0x17, 0x2D, 0x3A, 0x4E, 0x59, 0x63, 0x74, 0x8B, 0x9C, 0xA6, 0xB1, 0xC5, 0xD2, 0xE8, 0xFF. A rejected start sets status bit 1, gives no engine start and leaves busy low.
- R7: Writing 1 to status bits 2:0 clears them; writing 0 leaves them. Clearing bit 1 also clears the error index and the acknowledge.
- R8: irq_o is high exactly when control bit 1 is set and some status bit 2:0 is pending with its interrupt mask bit (same position) set.
- R9: Writing control bit 6 during a transfer ends it. eng_abort_o pulses for one cycle and status bit 1 is set. A later done is then ignored.
- R10: Writing device mode with bit 31 set while idle starts the initialisation. eng_init_o goes high, eng_start_o pulses and eng_wdata_o carries bits 23:0 of that register. Bit 31 reads 1 until done, then 0, and the status register is not changed.
- R11: Writing control bit 0 returns every register to zero in the next cycle, and bit 0 never reads back as 1.
- R12: Line control bits 3:0 drive scl_lvl_o, scl_ovr_o, sda_lvl_o and sda_ovr_o, in that order from bit 3 down. Bits 5 and 4 read scl_i and sda_i, and writes to them are ignored.
- R13: Clock register bits 7:0 drive clk_div_o and bits 10:8 drive sda_dly_o. The address register keeps the runtime address in bits 23:16 and the hardware address in bits 11:0 only, so bits 15:12 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| eng_start_o | output | 1 | One-cycle launch pulse to the serial engine |
| eng_abort_o | output | 1 | One-cycle abort pulse to the engine |
| eng_init_o | output | 1 | High while the device-mode initialisation runs |
| eng_cmd_o | output | 8 | Command code |
| eng_regaddr_o | output | 8 | Slave register address |
| eng_rta_o | output | 8 | Runtime address |
| eng_hwaddr_o | output | 12 | Hardware device address |
| eng_wdata_o | output | 32 | Write data, or the init word during initialisation |
| eng_done_i | input | 1 | Engine finished the current operation |
| eng_err_i | input | 1 | The operation failed (valid with done) |
| eng_err_idx_i | input | 4 | Failing byte index (valid with done) |
| eng_err_ack_i | input | 1 | Error acknowledge flag (valid with done) |
| eng_rdata_i | input | 32 | Read data (valid with done) |
| clk_div_o | output | 8 | Serial clock divider |
| sda_dly_o | output | 3 | Data output delay |
| scl_i | input | 1 | Live clock wire level |
| sda_i | input | 1 | Live data wire level |
| scl_ovr_o | output | 1 | Manual clock wire override enable |
| scl_lvl_o | output | 1 | Manual clock wire level |
| sda_ovr_o | output | 1 | Manual data wire override enable |
| sda_lvl_o | output | 1 | Manual data wire level |
| irq_o | output | 1 | Level interrupt |

## Verification
A register write that is sampled at one rising edge takes effect at that edge. Status, busy, data, irq_o and the configuration outputs therefore change there, and eng_start_o and eng_abort_o are high for the whole of the following cycle. An engine done sampled at an edge updates the status and the data register at that same edge. The bench drives every input on falling edges and samples outputs and combinational read data on falling edges, exactly one edge after the stimulus, so every result is seen in the first cycle it is due.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int REG_W = 32;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_CLK  = 'h04;
  localparam int OFF_INTE = 'h08;
  localparam int OFF_STS  = 'h0C;
  localparam int OFF_RADR = 'h10;
  localparam int OFF_DATA = 'h1C;
  localparam int OFF_LINE = 'h24;
  localparam int OFF_DMOD = 'h28;
  localparam int OFF_CMD  = 'h2C;
  localparam int OFF_DAR  = 'h30;

  localparam logic [7:0] CMD_RD8  = 8'h8B;
  localparam logic [7:0] CMD_RD16 = 8'h9C;
  localparam logic [7:0] CMD_RD32 = 8'hA6;
  localparam logic [7:0] CMD_WR8  = 8'h4E;
  localparam logic [7:0] CMD_WR16 = 8'h59;
  localparam logic [7:0] CMD_WR32 = 8'h63;
  localparam logic [7:0] CMD_SRTA = 8'hE8;

  localparam int NUM_SRC = 3;

  function automatic logic rta_ok(input logic [7:0] a);
    case (a)
      8'h17, 8'h2D, 8'h3A, 8'h4E, 8'h59, 8'h63, 8'h74, 8'h8B,
      8'h9C, 8'hA6, 8'hB1, 8'hC5, 8'hD2, 8'hE8, 8'hFF: rta_ok = 1'b1;
      default: rta_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/twb_cmd_check.sv
module twb_cmd_check
  import twb_pkg::*;
(
  input  logic [7:0]       cmd_i,
  input  logic [7:0]       rta_i,
  output logic             legal_o,
  output logic             is_read_o,
  output logic [REG_W-1:0] rd_mask_o
);
  logic known;

  always_comb begin
    known     = 1'b1;
    is_read_o = 1'b0;
    rd_mask_o = '0;
    case (cmd_i)
      CMD_RD8:  begin is_read_o = 1'b1; rd_mask_o = REG_W'(32'h0000_00FF); end
      CMD_RD16: begin is_read_o = 1'b1; rd_mask_o = REG_W'(32'h0000_FFFF); end
      CMD_RD32: begin is_read_o = 1'b1; rd_mask_o = '1; end
      CMD_WR8, CMD_WR16, CMD_WR32, CMD_SRTA: ;
      default:  known = 1'b0;
    endcase
    legal_o = known && ((cmd_i != CMD_SRTA) || rta_ok(rta_i));
  end
endmodule

// File: rtl/twb_xfer_ctl.sv
module twb_xfer_ctl #(
  parameter int NSRC  = 3,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             go_i,
  input  logic             abort_i,
  input  logic             init_i,
  input  logic             legal_i,
  input  logic             done_i,
  input  logic             err_i,
  input  logic [IDX_W-1:0] err_idx_i,
  input  logic             err_ack_i,
  input  logic             w1c_we_i,
  input  logic [NSRC-1:0]  w1c_i,
  output logic             xbusy_o,
  output logic             ibusy_o,
  output logic             start_o,
  output logic             abort_o,
  output logic [NSRC-1:0]  sts_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             ack_o,
  output logic             ok_o
);
  localparam int B_DONE = 0;
  localparam int B_ERR  = 1;
  localparam int B_LBSY = 2;

  logic xb_q, xb_d, ib_q, ib_d, st_q, st_d, ab_q, ab_d, ack_q, ack_d;
  logic [NSRC-1:0]  sts_q, sts_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign ok_o = done_i & xb_q & ~err_i & ~abort_i;

  always_comb begin
    xb_d = xb_q; ib_d = ib_q; st_d = 1'b0; ab_d = 1'b0;
    sts_d = sts_q; idx_d = idx_q; ack_d = ack_q;
    if (w1c_we_i) begin
      sts_d = sts_q & ~w1c_i;
      if (w1c_i[B_ERR]) begin idx_d = '0; ack_d = 1'b0; end
    end
    if (go_i) begin
      if (xb_q || ib_q) sts_d[B_LBSY] = 1'b1;
      else if (!legal_i) begin
        sts_d[B_ERR] = 1'b1; idx_d = '0; ack_d = 1'b0;
      end else begin
        xb_d = 1'b1; st_d = 1'b1;
      end
    end
    if (init_i) begin
      if (xb_q || ib_q) sts_d[B_LBSY] = 1'b1;
      else begin ib_d = 1'b1; st_d = 1'b1; end
    end
    if (abort_i && xb_q) begin
      xb_d = 1'b0; ab_d = 1'b1; sts_d[B_ERR] = 1'b1;
    end else if (done_i && xb_q) begin
      xb_d = 1'b0;
      if (err_i) begin
        sts_d[B_ERR] = 1'b1; idx_d = err_idx_i; ack_d = err_ack_i;
      end else sts_d[B_DONE] = 1'b1;
    end
    if (done_i && ib_q) ib_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xb_q <= 1'b0; ib_q <= 1'b0; st_q <= 1'b0; ab_q <= 1'b0;
      sts_q <= '0; idx_q <= '0; ack_q <= 1'b0;
    end else if (clear_i) begin
      xb_q <= 1'b0; ib_q <= 1'b0; st_q <= 1'b0; ab_q <= 1'b0;
      sts_q <= '0; idx_q <= '0; ack_q <= 1'b0;
    end else begin
      xb_q <= xb_d; ib_q <= ib_d; st_q <= st_d; ab_q <= ab_d;
      sts_q <= sts_d; idx_q <= idx_d; ack_q <= ack_d;
    end
  end

  assign xbusy_o = xb_q;
  assign ibusy_o = ib_q;
  assign start_o = st_q;
  assign abort_o = ab_q;
  assign sts_o   = sts_q;
  assign idx_o   = idx_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/twb_irq.sv
module twb_irq #(
  parameter int NSRC = 3
) (
  input  logic            gie_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] pend_i,
  output logic            irq_o
);
  logic [NSRC-1:0] hit;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    assign hit[gi] = en_i[gi] & pend_i[gi];
  end

  assign irq_o = gie_i & (|hit);
endmodule

// File: rtl/twb_host_regs.sv
module twb_host_regs
  import twb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 3,
  parameter int HW_W   = 12,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              eng_start_o,
  output logic              eng_abort_o,
  output logic              eng_init_o,
  output logic [7:0]        eng_cmd_o,
  output logic [7:0]        eng_regaddr_o,
  output logic [7:0]        eng_rta_o,
  output logic [HW_W-1:0]   eng_hwaddr_o,
  output logic [REG_W-1:0]  eng_wdata_o,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  input  logic [IDX_W-1:0]  eng_err_idx_i,
  input  logic              eng_err_ack_i,
  input  logic [REG_W-1:0]  eng_rdata_i,
  output logic [DIV_W-1:0]  clk_div_o,
  output logic [DLY_W-1:0]  sda_dly_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_ovr_o,
  output logic              scl_lvl_o,
  output logic              sda_ovr_o,
  output logic              sda_lvl_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(OFF_CLK);
  localparam logic [ADDR_W-1:0] A_INTE = ADDR_W'(OFF_INTE);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFF_STS);
  localparam logic [ADDR_W-1:0] A_RADR = ADDR_W'(OFF_RADR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(OFF_LINE);
  localparam logic [ADDR_W-1:0] A_DMOD = ADDR_W'(OFF_DMOD);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_DAR  = ADDR_W'(OFF_DAR);
  localparam int DM_W = 24;

  logic               gie_q;
  logic [DIV_W-1:0]   div_q;
  logic [DLY_W-1:0]   dly_q;
  logic [NUM_SRC-1:0] inte_q;
  logic [7:0]         radr_q, cmd_q, rta_q;
  logic [REG_W-1:0]   data_q;
  logic [3:0]         line_q;
  logic [DM_W-1:0]    dmod_q;
  logic [HW_W-1:0]    hw_q;

  logic wr_ctrl, soft_rst, go, abort_req, init_req;
  logic cmd_legal, cmd_read, xfer_ok, xfer_busy, init_busy, err_ack;
  logic [REG_W-1:0]   rd_mask;
  logic [NUM_SRC-1:0] sts_bits;
  logic [IDX_W-1:0]   err_idx;

  assign wr_ctrl   = reg_we_i && (reg_addr_i == A_CTRL);
  assign soft_rst  = wr_ctrl && reg_wdata_i[0];
  assign go        = wr_ctrl && reg_wdata_i[7] && !soft_rst;
  assign abort_req = wr_ctrl && reg_wdata_i[6] && !soft_rst;
  assign init_req  = reg_we_i && (reg_addr_i == A_DMOD) && reg_wdata_i[31];

  twb_cmd_check u_chk (
    .cmd_i     (cmd_q),
    .rta_i     (rta_q),
    .legal_o   (cmd_legal),
    .is_read_o (cmd_read),
    .rd_mask_o (rd_mask)
  );

  twb_xfer_ctl #(.NSRC(NUM_SRC), .IDX_W(IDX_W)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (soft_rst),
    .go_i      (go),
    .abort_i   (abort_req),
    .init_i    (init_req),
    .legal_i   (cmd_legal),
    .done_i    (eng_done_i),
    .err_i     (eng_err_i),
    .err_idx_i (eng_err_idx_i),
    .err_ack_i (eng_err_ack_i),
    .w1c_we_i  (reg_we_i && (reg_addr_i == A_STS)),
    .w1c_i     (reg_wdata_i[NUM_SRC-1:0]),
    .xbusy_o   (xfer_busy),
    .ibusy_o   (init_busy),
    .start_o   (eng_start_o),
    .abort_o   (eng_abort_o),
    .sts_o     (sts_bits),
    .idx_o     (err_idx),
    .ack_o     (err_ack),
    .ok_o      (xfer_ok)
  );

  twb_irq #(.NSRC(NUM_SRC)) u_irq (
    .gie_i  (gie_q),
    .en_i   (inte_q),
    .pend_i (sts_bits),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0; div_q <= '0; dly_q <= '0; inte_q <= '0;
      radr_q <= '0; cmd_q <= '0; rta_q <= '0; data_q <= '0;
      line_q <= '0; dmod_q <= '0; hw_q <= '0;
    end else if (soft_rst) begin
      gie_q <= 1'b0; div_q <= '0; dly_q <= '0; inte_q <= '0;
      radr_q <= '0; cmd_q <= '0; rta_q <= '0; data_q <= '0;
      line_q <= '0; dmod_q <= '0; hw_q <= '0;
    end else begin
      if (wr_ctrl) gie_q <= reg_wdata_i[1];
      if (reg_we_i) begin
        case (reg_addr_i)
          A_CLK:  begin div_q <= reg_wdata_i[DIV_W-1:0]; dly_q <= reg_wdata_i[8 +: DLY_W]; end
          A_INTE: inte_q <= reg_wdata_i[NUM_SRC-1:0];
          A_RADR: radr_q <= reg_wdata_i[7:0];
          A_LINE: line_q <= reg_wdata_i[3:0];
          A_DMOD: dmod_q <= reg_wdata_i[DM_W-1:0];
          A_CMD:  cmd_q  <= reg_wdata_i[7:0];
          A_DAR:  begin rta_q <= reg_wdata_i[23:16]; hw_q <= reg_wdata_i[HW_W-1:0]; end
          default: ;
        endcase
      end
      // engine result beats a same-cycle software write
      if (xfer_ok && cmd_read) data_q <= eng_rdata_i & rd_mask;
      else if (reg_we_i && (reg_addr_i == A_DATA)) data_q <= reg_wdata_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: reg_rdata_o = REG_W'({xfer_busy, 5'b0, gie_q, 1'b0});
      A_CLK:  reg_rdata_o = REG_W'({dly_q, div_q});
      A_INTE: reg_rdata_o = REG_W'(inte_q);
      A_STS:  reg_rdata_o = REG_W'({err_ack, 4'b0, err_idx, 5'b0, sts_bits});
      A_RADR: reg_rdata_o = REG_W'(radr_q);
      A_DATA: reg_rdata_o = data_q;
      A_LINE: reg_rdata_o = REG_W'({scl_i, sda_i, line_q});
      A_DMOD: reg_rdata_o = REG_W'({init_busy, 7'b0, dmod_q});
      A_CMD:  reg_rdata_o = REG_W'(cmd_q);
      A_DAR:  reg_rdata_o = REG_W'({rta_q, 16'(hw_q)});
      default: reg_rdata_o = '0;
    endcase
  end

  assign eng_init_o    = init_busy;
  assign eng_cmd_o     = cmd_q;
  assign eng_regaddr_o = radr_q;
  assign eng_rta_o     = rta_q;
  assign eng_hwaddr_o  = hw_q;
  assign eng_wdata_o   = init_busy ? REG_W'(dmod_q) : data_q;
  assign clk_div_o     = div_q;
  assign sda_dly_o     = dly_q;
  assign scl_lvl_o     = line_q[3];
  assign scl_ovr_o     = line_q[2];
  assign sda_lvl_o     = line_q[1];
  assign sda_ovr_o     = line_q[0];
endmodule

// File: rtl/twb_host_regs_chk.sv
module twb_host_regs_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              eng_start_o,
  input logic              eng_init_o,
  input logic              eng_done_i,
  input logic              eng_err_i,
  input logic              xfer_busy,
  input logic [2:0]        sts_bits,
  input logic              cmd_legal
);
  logic go_wr;
  assign go_wr = reg_we_i && (reg_addr_i == '0) && reg_wdata_i[7]
                 && !reg_wdata_i[6] && !reg_wdata_i[0];

  // R2
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  // R3
  load_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_wr && xfer_busy && !eng_done_i) |=> (sts_bits[2] && xfer_busy && !eng_start_o));

  // R4
  done_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && xfer_busy && !eng_err_i && !reg_we_i) |=> (sts_bits[0] && !xfer_busy));

  // R6
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_wr && !xfer_busy && !eng_init_o && !cmd_legal) |=> (!eng_start_o && sts_bits[1] && !xfer_busy));

  // R10
  init_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_init_o && eng_done_i && !reg_we_i) |=> !eng_init_o);
endmodule

bind twb_host_regs twb_host_regs_chk #(.ADDR_W(ADDR_W)) u_regs_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .eng_start_o (eng_start_o),
  .eng_init_o  (eng_init_o),
  .eng_done_i  (eng_done_i),
  .eng_err_i   (eng_err_i),
  .xfer_busy   (xfer_busy),
  .sts_bits    (sts_bits),
  .cmd_legal   (cmd_legal)
);

// File: tb/twb_host_regs_bench.sv
`timescale 1ns/1ps
module twb_host_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        start, abrt, init, done = 1'b0, err = 1'b0, eack = 1'b0;
  logic [3:0]  eidx = '0;
  logic [31:0] erd = '0, ewd;
  logic [7:0]  ecmd, eradr, erta, div;
  logic [11:0] ehw;
  logic [2:0]  dly;
  logic        scl = 1'b1, sda = 1'b1, scl_ovr, scl_lvl, sda_ovr, sda_lvl, irq;

  twb_host_regs u_twb_host_regs (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .eng_start_o(start), .eng_abort_o(abrt), .eng_init_o(init),
    .eng_cmd_o(ecmd), .eng_regaddr_o(eradr), .eng_rta_o(erta),
    .eng_hwaddr_o(ehw), .eng_wdata_o(ewd), .eng_done_i(done),
    .eng_err_i(err), .eng_err_idx_i(eidx), .eng_err_ack_i(eack),
    .eng_rdata_i(erd), .clk_div_o(div), .sda_dly_o(dly),
    .scl_i(scl), .sda_i(sda), .scl_ovr_o(scl_ovr), .scl_lvl_o(scl_lvl),
    .sda_ovr_o(sda_ovr), .sda_lvl_o(sda_lvl), .irq_o(irq)
  );

  localparam logic [5:0] O_CTRL = 6'h00, O_CLK = 6'h04, O_INTE = 6'h08,
    O_STS = 6'h0C, O_DATA = 6'h1C, O_LINE = 6'h24, O_DMOD = 6'h28,
    O_CMD = 6'h2C, O_DAR = 6'h30;

  localparam int NV = 8;
  localparam logic [7:0]  V_CMD [NV] = '{8'h8B, 8'h9C, 8'hA6, 8'h4E, 8'hE8, 8'hE8, 8'h55, 8'h59};
  localparam logic [7:0]  V_RTA [NV] = '{8'h2D, 8'h2D, 8'h2D, 8'h2D, 8'h74, 8'h75, 8'h2D, 8'h2D};
  localparam logic        V_ERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic        V_GO  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [31:0] V_STS [NV] = '{32'h1, 32'h1, 32'h1, 32'h1, 32'h1, 32'h2, 32'h2, 32'h0001_0302};
  localparam logic [31:0] V_DAT [NV] = '{32'hA5, 32'h56A5, 32'h1234_56A5, 32'hC3, 32'hC3, 32'hC3, 32'hC3, 32'hC3};

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic fin(input logic e, input logic [3:0] ix, input logic [31:0] rv);
    @(negedge clk); done = 1'b1; err = e; eidx = ix; eack = e; erd = rv;
    @(negedge clk); done = 1'b0; err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(O_CTRL, v); chk("R1 ctrl", v, 0);
    rd(O_STS, v);  chk("R1 sts", v, 0);
    rd(O_DATA, v); chk("R1 data", v, 0);
    rd(O_DAR, v);  chk("R1 dar", v, 0);
    rd(O_DMOD, v); chk("R1 dmod", v, 0);
    chk("R1 outs", {28'b0, irq, start, abrt, init}, 0);

    // vector table: R2 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      wr(O_STS, 32'h7);
      wr(O_DATA, 32'hC3);
      wr(O_DAR, {8'h0, V_RTA[i], 16'h0ABC});
      wr(O_CMD, {24'h0, V_CMD[i]});
      wr(O_CTRL, 32'h82);
      chk($sformatf("R2 R6 start vec%0d", i), {31'b0, start}, {31'b0, V_GO[i]});
      rd(O_CTRL, v);
      chk($sformatf("R2 busy vec%0d", i), v, V_GO[i] ? 32'h82 : 32'h02);
      if (V_GO[i]) begin
        chk($sformatf("R2 eng fields vec%0d", i), {ecmd, erta, 4'b0, ehw}, {V_CMD[i], V_RTA[i], 16'h0ABC});
        fin(V_ERR[i], 4'd3, 32'h1234_56A5);
      end
      rd(O_STS, v);  chk($sformatf("R4 R5 status vec%0d", i), v, V_STS[i]);
      rd(O_DATA, v); chk($sformatf("R4 data vec%0d", i), v, V_DAT[i]);
    end

    // R3 load while busy
    wr(O_STS, 32'h7);
    wr(O_DAR, 32'h002D_0000);
    wr(O_CMD, 32'h8B);
    wr(O_CTRL, 32'h82);
    wr(O_CTRL, 32'h82);
    chk("R3 no restart", {31'b0, start}, 0);
    rd(O_CTRL, v); chk("R3 still busy", v, 32'h82);
    rd(O_STS, v);  chk("R3 load busy flag", v, 32'h4);
    fin(1'b0, 4'd0, 32'h0000_0177);
    rd(O_STS, v);  chk("R3 R4 after done", v, 32'h5);
    rd(O_DATA, v); chk("R4 rd8 width", v, 32'h77);

    // R8 interrupt gating
    chk("R8 mask off", {31'b0, irq}, 0);
    wr(O_INTE, 32'h1);
    chk("R8 enabled", {31'b0, irq}, 1);
    wr(O_CTRL, 32'h0);
    chk("R8 global off", {31'b0, irq}, 0);
    wr(O_CTRL, 32'h2);
    chk("R8 global on", {31'b0, irq}, 1);
    // R7 write-one-to-clear
    wr(O_STS, 32'h1);
    rd(O_STS, v); chk("R7 clear bit0 only", v, 32'h4);
    chk("R8 after clear", {31'b0, irq}, 0);
    wr(O_STS, 32'h0);
    rd(O_STS, v); chk("R7 zero write keeps", v, 32'h4);

    // R9 abort
    wr(O_STS, 32'h7);
    wr(O_CMD, 32'h4E);
    wr(O_CTRL, 32'h82);
    wr(O_CTRL, 32'h42);
    chk("R9 abort pulse", {31'b0, abrt}, 1);
    rd(O_CTRL, v); chk("R9 not busy", v, 32'h02);
    fin(1'b0, 4'd0, 32'h0);
    rd(O_STS, v); chk("R9 late done ignored", v, 32'h2);

    // R10 device-mode init
    wr(O_STS, 32'h7);
    wr(O_DMOD, 32'h807C_3E00);
    chk("R10 start pulse", {31'b0, start}, 1);
    chk("R10 init level", {31'b0, init}, 1);
    chk("R10 init word", ewd, 32'h007C_3E00);
    rd(O_DMOD, v); chk("R10 busy bit", v, 32'h807C_3E00);
    wr(O_CTRL, 32'h82);
    rd(O_STS, v); chk("R10 R3 start during init", v, 32'h4);
    fin(1'b0, 4'd0, 32'h0);
    rd(O_DMOD, v); chk("R10 self clear", v, 32'h007C_3E00);
    chk("R10 init low", {31'b0, init}, 0);
    rd(O_STS, v); chk("R10 status untouched", v, 32'h4);

    // R12 line control
    scl = 1'b0; sda = 1'b1;
    wr(O_LINE, 32'h3A);
    chk("R12 outputs", {28'b0, scl_lvl, scl_ovr, sda_lvl, sda_ovr}, 32'hA);
    rd(O_LINE, v); chk("R12 readback", v, 32'h1A);

    // R13 clock and address widths
    wr(O_CLK, 32'h0000_FFA5);
    chk("R13 div", {24'b0, div}, 32'hA5);
    chk("R13 dly", {29'b0, dly}, 32'h7);
    rd(O_CLK, v); chk("R13 clk read", v, 32'h7A5);
    wr(O_DAR, 32'hFF74_FABC);
    rd(O_DAR, v); chk("R13 dar read", v, 32'h0074_0ABC);
    chk("R13 hw out", {20'b0, ehw}, 32'hABC);

    // R11 soft reset
    wr(O_INTE, 32'h7);
    wr(O_CTRL, 32'h83);
    chk("R11 no start", {31'b0, start}, 0);
    rd(O_CTRL, v); chk("R11 ctrl", v, 0);
    rd(O_INTE, v); chk("R11 inte", v, 0);
    rd(O_STS, v);  chk("R11 sts", v, 0);
    rd(O_CLK, v);  chk("R11 clk", v, 0);
    rd(O_LINE, v); chk("R11 line", v, 32'h10);
    rd(O_DAR, v);  chk("R11 dar", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule